// File: doc/BRIEF.md
# Dual-Mode Limit Counter-Timer

This block is one counter/timer channel. It sits behind a 32-bit register interface that is addressed by word, and it drives one interrupt line. A one-cycle `tick` pulse marks each 500 ns period. Each tick adds one at bit position `TICK_SHIFT`, which is 9 by default, so the low nine bits of every count value read as zero.

The external `user_mode` pin selects how the channel behaves. In counting mode the channel runs up to a programmable limit. When it gets there it returns to zero, sets a reached flag and raises `irq`. The flag and the interrupt stay set until software reads the limit word. A limit of zero makes the counter free-running: it wraps at the top of its field, sets the flag, and raises no interrupt. In user mode the same words give access to a 63-bit counter. Software loads it in two halves and starts or stops it. This counter never interrupts.

Mode handling is a three-state machine:
- `ST_CNT` is counting mode.
- `ST_USR_IDLE` is user mode with the counter stopped.
- `ST_USR_RUN` is user mode with the counter running.

It has four transitions:
- ENTER goes from `ST_CNT` to `ST_USR_IDLE` when `user_mode` is high.
- LEAVE goes from either user state to `ST_CNT` when `user_mode` is low.
- START goes from idle to run when word 3 is written with bit 0 set.
- STOP goes from run to idle when word 3 is written with bit 0 clear.

Top module: `limit_timer`

## Requirements
- R1: After reset, the limit, the count, the reached flag and `irq` are all zero, the channel is in counting mode, and word 3 reads 1 (running).
- R2: In counting mode, every `tick` adds one at bit `TICK_SHIFT`. Reading word 1 returns the count in bits `CNT_W-1..TICK_SHIFT`, zeros in the bits below, and the reached flag in bit 31.
- R3: When the limit is nonzero and a tick would bring the count to the limit, the count goes to zero instead, and the reached flag and `irq` are set. This repeats every limit periods.
- R4: In counting mode, reading word 0 returns the limit (bits `CNT_W-1..TICK_SHIFT`, all other bits zero) and clears both the reached flag and `irq`.
- R5: In counting mode, writing word 0 stores `wdata` bits `CNT_W-1..TICK_SHIFT` as the limit (0x7FFFFE00 mask at defaults). It also zeroes the count and clears the reached flag and `irq`.
- R6: Writing word 2 stores the limit with the same mask and leaves the count unchanged.
- R7: With a zero limit, the count wraps to zero on the tick that would bring it to 2^CNT_W − 2^TICK_SHIFT (0x7FFFFE00 at defaults). The reached flag is set at the wrap and `irq` stays low.
- R8: In user mode, the counter is the period count shifted left by `TICK_SHIFT`, 63 bits wide. Word 0 holds bits 62..32 and word 1 holds bits 31..0. Writing word 0 loads the upper half from `wdata` bits 30..0, and writing word 1 loads the lower half from `wdata` bits 31..9. Either write clears the reached flag. Reading word 0 returns the upper half with the reached flag in bit 31 and does not clear the flag. The flag is set when the counter wraps to zero.
- R9: In user mode, writing word 3 with bit 0 set starts the counter and writing it with bit 0 clear stops it. Word 3 reads the running status in bit 0. A stopped counter holds its value through ticks.
- R10: `irq` is never high while the channel is in user mode.
- R11: Entering user mode clears `irq`, the count, the reached flag and the limit, and leaves the counter stopped. Returning to counting mode clears the count and the reached flag, and counting resumes with the next tick. A tick in the cycle of either switch is dropped.
- R12: Words 4 to 7 ignore writes and read zero, and word 2 reads zero. In counting mode, writes to words 1 and 3 are ignored.
- R13: A register write takes precedence over a tick in the same cycle. A limit hit takes precedence over the clearing effect of a limit read in the same cycle, so the flag and `irq` stay set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle period pulse |
| user_mode | input | 1 | 1 selects user mode, 0 selects counting mode |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W (3) | Word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data; zero when `rd_en` is low |
| irq | output | 1 | Interrupt, level, registered |

## Verification
Read data is combinational from the current register state. It is therefore due in the same cycle as `rd_en`, and the bench samples it a few nanoseconds after the falling edge, before the edge that commits the access.

All other effects appear after exactly one rising edge. This covers a tick, a write, a limit-read clear and a mode switch, each of which changes the count, the limit, the flag, `irq` and the state. The bench drives each cycle's inputs on the falling edge and compares `rdata` and `irq` with its behavioural model before the next rising edge. It advances the model only after that edge, so every comparison lines up with that single register stage.

// File: rtl/dmt_pkg.sv
package dmt_pkg;

    // Mode/run state of the channel
    typedef enum logic [1:0] {
        ST_CNT      = 2'd0,
        ST_USR_IDLE = 2'd1,
        ST_USR_RUN  = 2'd2
    } dmt_state_e;

    // Word addresses (their meaning is decoded per mode)
    localparam int W_LIMIT      = 0;
    localparam int W_COUNT      = 1;
    localparam int W_LIMIT_KEEP = 2;
    localparam int W_CTRL       = 3;

endpackage

// File: rtl/dmt_fsm.sv
module dmt_fsm
    import dmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       user_mode,
    input  logic       ctl_wr,
    input  logic       ctl_run,
    output dmt_state_e state,
    output logic       enter,
    output logic       leave,
    output logic       cnt_mode,
    output logic       usr_run
);

    dmt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CNT;
        else        state_q <= state_d;
    end

    // transitions: ENTER, LEAVE, START, STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CNT: begin
                if (user_mode) state_d = ST_USR_IDLE;              // ENTER
            end
            ST_USR_IDLE: begin
                if (!user_mode)              state_d = ST_CNT;     // LEAVE
                else if (ctl_wr && ctl_run)  state_d = ST_USR_RUN; // START
            end
            ST_USR_RUN: begin
                if (!user_mode)              state_d = ST_CNT;     // LEAVE
                else if (ctl_wr && !ctl_run) state_d = ST_USR_IDLE;// STOP
            end
            default: state_d = ST_CNT;
        endcase
    end

    // outputs
    always_comb begin
        state    = state_q;
        enter    = (state_q == ST_CNT) && user_mode;
        leave    = (state_q != ST_CNT) && !user_mode;
        cnt_mode = (state_q == ST_CNT);
        usr_run  = (state_q == ST_USR_RUN);
    end

    AST_START_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_USR_RUN) |-> $past(ctl_wr && ctl_run)); // R9

endmodule

// File: rtl/dmt_count.sv
module dmt_count #(
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 31,
    parameter int TICK_SHIFT = 9,
    parameter int USER_W     = 63
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       cnt_mode,
    input  logic                       usr_run,
    input  logic                       enter,
    input  logic                       leave,
    input  logic                       rd_lim_clr,
    input  logic                       wr_lim_rst,
    input  logic                       wr_lim_keep,
    input  logic                       wr_hi,
    input  logic                       wr_lo,
    input  logic [DATA_W-1:0]          wdata,
    output logic [USER_W-TICK_SHIFT-1:0] cnt_q,
    output logic [CNT_W-TICK_SHIFT-1:0]  lim_q,
    output logic                       reached_q,
    output logic                       irq_q
);

    localparam int PER_W  = CNT_W - TICK_SHIFT;   // counting-mode period bits
    localparam int UPER_W = USER_W - TICK_SHIFT;  // user-mode period bits
    localparam int LO_W   = DATA_W - TICK_SHIFT;  // period bits in lower word
    localparam int HI_W   = UPER_W - LO_W;        // period bits in upper word
    localparam logic [PER_W-1:0] PER_MAX = '1;

    logic [UPER_W-1:0] cnt_d;
    logic [PER_W-1:0]  lim_d;
    logic              reached_d, irq_d;
    logic [PER_W-1:0]  per_nx;
    logic [UPER_W-1:0] usr_nx;
    logic              lim_hit, wrap_hit;

    always_comb begin
        per_nx   = cnt_q[PER_W-1:0] + PER_W'(1);
        usr_nx   = cnt_q + UPER_W'(1);
        lim_hit  = (lim_q != '0) && (per_nx == lim_q);
        wrap_hit = (per_nx == PER_MAX);

        cnt_d     = cnt_q;
        lim_d     = lim_q;
        reached_d = reached_q;
        irq_d     = irq_q;

        if (enter) begin
            cnt_d     = '0;
            lim_d     = '0;
            reached_d = 1'b0;
            irq_d     = 1'b0;
        end else if (leave) begin
            cnt_d     = '0;
            reached_d = 1'b0;
        end else begin
            if (rd_lim_clr) begin
                reached_d = 1'b0;
                irq_d     = 1'b0;
            end
            if (cnt_mode && tick) begin
                if (lim_hit || wrap_hit) begin
                    cnt_d     = '0;
                    reached_d = 1'b1;
                    if (lim_hit) irq_d = 1'b1;
                end else begin
                    cnt_d = UPER_W'(per_nx);
                end
            end
            if (usr_run && tick) begin
                cnt_d = usr_nx;
                if (usr_nx == '0) reached_d = 1'b1;
            end
            if (wr_lim_keep) lim_d = wdata[CNT_W-1:TICK_SHIFT];
            if (wr_lim_rst) begin
                lim_d     = wdata[CNT_W-1:TICK_SHIFT];
                cnt_d     = '0;
                reached_d = 1'b0;
                irq_d     = 1'b0;
            end
            if (wr_hi) begin
                cnt_d[UPER_W-1:LO_W] = wdata[HI_W-1:0];
                reached_d            = 1'b0;
            end
            if (wr_lo) begin
                cnt_d[LO_W-1:0] = wdata[DATA_W-1:TICK_SHIFT];
                reached_d       = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            lim_q     <= lim_d;
            reached_q <= reached_d;
            irq_q     <= irq_d;
        end
    end

    AST_IRQ_WITH_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> reached_q); // R3
    AST_CNT_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_mode |-> (cnt_q < UPER_W'(PER_MAX))); // R7
    AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_mode |-> !irq_q); // R10
    AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        enter |=> (cnt_q == '0 && lim_q == '0 && !reached_q && !irq_q)); // R11
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_mode && !usr_run && !wr_hi && !wr_lo && !leave) |=> $stable(cnt_q)); // R9
    AST_LIMIT_WRITE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lim_rst && !enter && !leave) |=> (cnt_q == '0 && !irq_q)); // R5

endmodule

// File: rtl/dmt_regs.sv
module dmt_regs
    import dmt_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 31,
    parameter int TICK_SHIFT = 9,
    parameter int USER_W     = 63
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  dmt_state_e                   state,
    input  logic [USER_W-TICK_SHIFT-1:0] cnt,
    input  logic [CNT_W-TICK_SHIFT-1:0]  limit,
    input  logic                         reached,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rd_lim_clr,
    output logic                         wr_lim_rst,
    output logic                         wr_lim_keep,
    output logic                         wr_hi,
    output logic                         wr_lo,
    output logic                         ctl_wr
);

    localparam int PER_W  = CNT_W - TICK_SHIFT;
    localparam int UPER_W = USER_W - TICK_SHIFT;

    logic              is_user, running;
    logic              a_lim, a_cnt, a_keep, a_ctl;
    logic [2*DATA_W-1:0] full;
    logic [DATA_W-1:0] lim_word, cnt_word, hi_word;

    always_comb begin
        is_user = (state != ST_CNT);
        running = (state == ST_CNT) || (state == ST_USR_RUN);
        a_lim   = (addr == ADDR_W'(W_LIMIT));
        a_cnt   = (addr == ADDR_W'(W_COUNT));
        a_keep  = (addr == ADDR_W'(W_LIMIT_KEEP));
        a_ctl   = (addr == ADDR_W'(W_CTRL));

        full     = {{(2*DATA_W-UPER_W){1'b0}}, cnt} << TICK_SHIFT;
        lim_word = DATA_W'({limit, {TICK_SHIFT{1'b0}}});
        cnt_word = DATA_W'({cnt[PER_W-1:0], {TICK_SHIFT{1'b0}}});
        cnt_word[DATA_W-1] = reached;
        hi_word  = full[2*DATA_W-1:DATA_W];
        hi_word[DATA_W-1] = hi_word[DATA_W-1] | reached;

        rdata = '0;
        if (rd_en) begin
            if (a_lim)      rdata = is_user ? hi_word : lim_word;
            else if (a_cnt) rdata = is_user ? full[DATA_W-1:0] : cnt_word;
            else if (a_ctl) rdata = DATA_W'(running);
        end

        rd_lim_clr  = rd_en && a_lim && !is_user;
        wr_lim_rst  = wr_en && a_lim && !is_user;
        wr_hi       = wr_en && a_lim && is_user;
        wr_lo       = wr_en && a_cnt && is_user;
        wr_lim_keep = wr_en && a_keep;
        ctl_wr      = wr_en && a_ctl && is_user;
    end

    AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && a_cnt && state == ST_CNT) |-> (rdata[TICK_SHIFT-1:0] == '0)); // R2
    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0)); // R12

endmodule

// File: rtl/limit_timer.sv
module limit_timer
    import dmt_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 31,
    parameter int TICK_SHIFT = 9,
    parameter int USER_W     = 63
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              user_mode,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    localparam int PER_W  = CNT_W - TICK_SHIFT;
    localparam int UPER_W = USER_W - TICK_SHIFT;

    dmt_state_e        state;
    logic              enter, leave, cnt_mode, usr_run;
    logic              rd_lim_clr, wr_lim_rst, wr_lim_keep, wr_hi, wr_lo, ctl_wr;
    logic [UPER_W-1:0] cnt;
    logic [PER_W-1:0]  limit;
    logic              reached;

    dmt_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .ctl_wr    (ctl_wr),
        .ctl_run   (wdata[0]),
        .state     (state),
        .enter     (enter),
        .leave     (leave),
        .cnt_mode  (cnt_mode),
        .usr_run   (usr_run)
    );

    dmt_regs #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .TICK_SHIFT (TICK_SHIFT),
        .USER_W     (USER_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_en       (rd_en),
        .wr_en       (wr_en),
        .addr        (addr),
        .state       (state),
        .cnt         (cnt),
        .limit       (limit),
        .reached     (reached),
        .rdata       (rdata),
        .rd_lim_clr  (rd_lim_clr),
        .wr_lim_rst  (wr_lim_rst),
        .wr_lim_keep (wr_lim_keep),
        .wr_hi       (wr_hi),
        .wr_lo       (wr_lo),
        .ctl_wr      (ctl_wr)
    );

    dmt_count #(
        .DATA_W     (DATA_W),
        .CNT_W      (CNT_W),
        .TICK_SHIFT (TICK_SHIFT),
        .USER_W     (USER_W)
    ) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cnt_mode    (cnt_mode),
        .usr_run     (usr_run),
        .enter       (enter),
        .leave       (leave),
        .rd_lim_clr  (rd_lim_clr),
        .wr_lim_rst  (wr_lim_rst),
        .wr_lim_keep (wr_lim_keep),
        .wr_hi       (wr_hi),
        .wr_lo       (wr_lo),
        .wdata       (wdata),
        .cnt_q       (cnt),
        .lim_q       (limit),
        .reached_q   (reached),
        .irq_q       (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq); // R1

endmodule

// File: tb/limit_timer_bench.sv
module limit_timer_bench;

    localparam int CW   = 16;
    localparam int TS   = 9;
    localparam int UW   = 63;
    localparam int DW   = 32;
    localparam int AW   = 3;
    localparam int PW   = CW - TS;
    localparam int PMAX = (1 << PW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0, user_mode = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    always #10 clk = ~clk;   // 50 MHz

    limit_timer #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .TICK_SHIFT(TS), .USER_W(UW)) u_limit_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur = "R1";

    // behavioural reference state
    bit          m_user = 0, m_run = 0, m_reached = 0, m_irq = 0;
    logic [53:0] m_cnt = '0;
    int          m_lim = 0;

    function automatic logic [31:0] model_read();
        logic [63:0] full;
        full = {10'b0, m_cnt} << TS;
        if (!rd_en) return 32'h0;
        case (addr)
            3'd0: return m_user ? (full[63:32] | ({31'b0, m_reached} << 31)) : (32'(m_lim) << TS);
            3'd1: return m_user ? full[31:0] : (({31'b0, m_reached} << 31) | (32'(m_cnt[PW-1:0]) << TS));
            3'd3: return {31'b0, (!m_user || m_run)};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_update();
        int nx;
        if (!m_user && user_mode) begin
            m_user = 1; m_run = 0; m_cnt = '0; m_reached = 0; m_irq = 0; m_lim = 0;
        end else if (m_user && !user_mode) begin
            m_user = 0; m_cnt = '0; m_reached = 0;
        end else begin
            if (rd_en && addr == 3'd0 && !m_user) begin m_reached = 0; m_irq = 0; end
            if (tick && !m_user) begin
                nx = int'(m_cnt[PW-1:0]) + 1;
                if ((m_lim != 0 && nx == m_lim) || nx == PMAX) begin
                    if (m_lim != 0 && nx == m_lim) m_irq = 1;
                    m_cnt = '0; m_reached = 1;
                end else m_cnt = 54'(nx);
            end
            if (tick && m_user && m_run) begin
                m_cnt = m_cnt + 54'd1;
                if (m_cnt == '0) m_reached = 1;
            end
            if (wr_en) begin
                case (addr)
                    3'd0: if (m_user) begin m_cnt[53:23] = wdata[30:0]; m_reached = 0; end
                          else begin m_lim = int'(wdata >> TS) & PMAX; m_cnt = '0; m_reached = 0; m_irq = 0; end
                    3'd1: if (m_user) begin m_cnt[22:0] = wdata[31:9]; m_reached = 0; end
                    3'd2: m_lim = int'(wdata >> TS) & PMAX;
                    3'd3: if (m_user) m_run = wdata[0];
                    default: ;
                endcase
            end
        end
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(bit t, bit r, bit w, int a, logic [31:0] d);
        tick = t; rd_en = r; wr_en = w; addr = a[AW-1:0]; wdata = d;
    endtask

    task automatic finish_cycle();
        #2;
        check({cur, " rdata vs model"}, rdata, model_read());
        check({cur, " irq vs model"}, {31'b0, irq}, {31'b0, m_irq});
        @(posedge clk);
        model_update();
        @(negedge clk);
        drive(0, 0, 0, 0, 32'h0);
    endtask

    task automatic step(bit t, bit r, bit w, int a, logic [31:0] d);
        drive(t, r, w, a, d);
        finish_cycle();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 32'h0);
    endtask

    task automatic rd(int a, logic [31:0] exp, string tag);
        drive(0, 1, 0, a, 32'h0);
        #1;
        check(tag, rdata, exp);
        finish_cycle();
    endtask

    task automatic chk_irq(bit exp, string tag);
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cur = "R1";
        chk_irq(0, "R1 irq after reset");
        rd(0, 32'h0, "R1 limit zero");
        rd(1, 32'h0, "R1 count zero");
        rd(3, 32'h1, "R1 running");

        cur = "R2";
        ticks(3);
        rd(1, 32'h600, "R2 three periods");
        ticks(1);
        rd(1, 32'h800, "R2 four periods");

        cur = "R6";
        step(0, 0, 1, 2, 32'h0000_0DFF);
        rd(1, 32'h800, "R6 count kept");
        rd(0, 32'hC00, "R6 limit masked");

        cur = "R3";
        ticks(2);
        chk_irq(1, "R3 irq at limit");
        rd(1, 32'h8000_0000, "R3 count wrapped reached");
        cur = "R4";
        rd(0, 32'hC00, "R4 limit read");
        chk_irq(0, "R4 irq cleared");
        rd(1, 32'h0, "R4 reached cleared");
        cur = "R3";
        ticks(5);
        chk_irq(0, "R3 not yet");
        ticks(1);
        chk_irq(1, "R3 recurs");

        cur = "R5";
        step(0, 0, 1, 0, 32'h0000_0BFF);
        chk_irq(0, "R5 irq cleared");
        rd(1, 32'h0, "R5 count reset");
        rd(0, 32'hA00, "R5 limit masked");
        step(0, 0, 1, 0, 32'h8000_0A00);
        rd(0, 32'hA00, "R5 high bits masked");

        cur = "R13";
        ticks(4);
        step(1, 0, 1, 0, 32'h0000_0A00);
        rd(1, 32'h0, "R13 write beats tick");
        ticks(4);
        step(1, 1, 0, 0, 32'h0);
        chk_irq(1, "R13 hit beats read clear");
        rd(1, 32'h8000_0000, "R13 reached kept");

        cur = "R7";
        step(0, 0, 1, 0, 32'h0);
        ticks(PMAX - 1);
        rd(1, 32'hFC00, "R7 before wrap");
        ticks(1);
        chk_irq(0, "R7 no irq");
        rd(1, 32'h8000_0000, "R7 wrap reached");
        rd(0, 32'h0, "R7 limit zero");

        cur = "R12";
        ticks(2);
        step(0, 0, 1, 1, 32'hFFFF_FFFF);
        rd(1, 32'h400, "R12 count write ignored");
        step(0, 0, 1, 3, 32'h0);
        rd(3, 32'h1, "R12 ctrl write ignored");
        step(0, 0, 1, 5, 32'hFFFF_FFFF);
        rd(0, 32'h0, "R12 unused write no limit");
        rd(5, 32'h0, "R12 word5 zero");
        rd(7, 32'h0, "R12 word7 zero");
        rd(2, 32'h0, "R12 word2 zero");

        cur = "R11";
        step(0, 0, 1, 0, 32'h0000_0600);
        ticks(3);
        chk_irq(1, "R11 irq before entry");
        user_mode = 1'b1;
        step(0, 0, 0, 0, 32'h0);
        chk_irq(0, "R11 entry clears irq");
        rd(3, 32'h0, "R11 stopped");
        rd(1, 32'h0, "R11 count cleared");
        rd(0, 32'h0, "R11 upper and reached clear");

        cur = "R9";
        ticks(3);
        rd(1, 32'h0, "R9 stopped ignores ticks");

        cur = "R8";
        step(0, 0, 1, 1, 32'h1234_5FFF);
        step(0, 0, 1, 0, 32'h8000_0055);
        rd(0, 32'h0000_0055, "R8 upper half");
        rd(1, 32'h1234_5E00, "R8 lower half");

        cur = "R9";
        step(0, 0, 1, 3, 32'h1);
        rd(3, 32'h1, "R9 running");
        ticks(2);
        rd(1, 32'h1234_6200, "R9 counts");
        step(0, 0, 1, 3, 32'h0);
        ticks(2);
        rd(1, 32'h1234_6200, "R9 stop holds");
        rd(3, 32'h0, "R9 status stopped");

        cur = "R8";
        step(0, 0, 1, 0, 32'h7FFF_FFFF);
        step(0, 0, 1, 1, 32'hFFFF_FE00);
        step(0, 0, 1, 3, 32'h1);
        ticks(1);
        rd(0, 32'h8000_0000, "R8 wrap reached bit31");
        rd(0, 32'h8000_0000, "R8 read keeps reached");
        chk_irq(0, "R10 no irq in user mode");
        step(0, 0, 1, 1, 32'h0);
        rd(0, 32'h0, "R8 load clears reached");

        cur = "R11";
        ticks(2);
        rd(1, 32'h400, "R11 user count before leave");
        user_mode = 1'b0;
        step(1, 0, 0, 0, 32'h0);
        rd(1, 32'h0, "R11 return clears count");
        rd(3, 32'h1, "R11 running again");
        rd(0, 32'h0, "R11 limit zero after entry");
        ticks(2);
        rd(1, 32'h400, "R11 resumes counting");

        summary();
    end

endmodule